// File: doc/BRIEF.md
# Two-Port Memory Request Arbiter

This block lets two requesters share a single graphics memory port. Port A serves the host CPU bridge and port B serves a serial debug link. Each requester signals a transfer with a one-clock write strobe or a one-clock read strobe, together with an address and write data. The arbiter puts one transfer at a time on the memory side, in the same cycle it is granted. Port A wins whenever both ports want the memory.

A strobe that cannot be served in its own cycle is parked in a one-entry holding slot for that port. It is issued in the first cycle in which the memory side is free. The memory returns read data a fixed two clocks after the read strobe. A small tag pipeline remembers which port made each read, so that the returned byte and a one-clock valid pulse reach only that port. Each requester is expected to latch its own returned byte.

Top module: `mem_share_arb`

## Requirements
- R1: In a cycle with no transfer issued, `mem_wr_o` and `mem_rd_o` are low, and `mem_addr_o`/`mem_wdata_o` show port A's next candidate: its held request if one exists, otherwise its live inputs.
- R2: When the memory side is free and port A has a live strobe or a held request, that request appears on the memory side in the same cycle. A held request is issued before a live one.
- R3: When the memory side is free and port A has nothing to do, port B's held or live request appears on the memory side in the same cycle.
- R4: When both ports strobe in the same free cycle, port A is issued in that cycle. Port B's request is held and issued in the next free cycle.
- R5: A read issued in cycle t gives a one-cycle valid pulse in cycle t+2 on the port that made it. That port's read-data output equals `mem_rdata_i` in that cycle, and the other port's valid output stays low.
- R6: In the two cycles after a read is issued, no strobe reaches the memory side. Strobes arriving in those cycles are held and issued in the first free cycle.
- R7: A write gives no valid pulse on either port and does not block a transfer in the following cycle.
- R8: `mem_wr_o` and `mem_rd_o` are never high together.
- R9: Asserting `rst_n` low drops all held requests and all reads in flight. No valid pulse and no held transfer appears after the release.
- R10: When both ports hold a request as the memory side becomes free, port A's request is issued first and port B's follows in the next free cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr_i | input | 20 | Port A address |
| a_wdata_i | input | 8 | Port A write data |
| a_wr_i | input | 1 | Port A one-clock write strobe |
| a_rd_i | input | 1 | Port A one-clock read strobe |
| a_rdata_o | output | 8 | Returned read data for port A |
| a_rvalid_o | output | 1 | Port A read-data valid pulse |
| b_addr_i | input | 20 | Port B address |
| b_wdata_i | input | 8 | Port B write data |
| b_wr_i | input | 1 | Port B one-clock write strobe |
| b_rd_i | input | 1 | Port B one-clock read strobe |
| b_rdata_o | output | 8 | Returned read data for port B |
| b_rvalid_o | output | 1 | Port B read-data valid pulse |
| mem_addr_o | output | 20 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Memory read data, valid two clocks after the read strobe |

## Verification
The bench uses the default parameters: a 20-bit address, 8-bit data and a read latency of two clocks. Its reference model assumes the same two-clock return window. With these values, every collision is reachable in a few cycles:
- strobes landing in either cycle of a read's blackout window;
- both holding slots filled at once;
- a held request and a fresh strobe meeting on the same port as its slot drains.

The bench also includes directed sequences and a long stretch of random traffic. A reset is applied while a read is in flight and a request is held.

// File: rtl/msa_pkg.sv
package msa_pkg;
  localparam int NUM_PORTS = 2;
  localparam int PORT_A    = 0;
  localparam int PORT_B    = 1;

  typedef enum logic {
    TAG_A = 1'b0,
    TAG_B = 1'b1
  } ret_tag_e;
endpackage

// File: rtl/msa_hold_slot.sv
module msa_hold_slot #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live_wr,
  input  logic              live_rd,
  input  logic [ADDR_W-1:0] live_addr,
  input  logic [DATA_W-1:0] live_wdata,
  input  logic              take,
  output logic              req,
  output logic              sel_wr,
  output logic              sel_rd,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [DATA_W-1:0] sel_wdata
);
  logic              hold_v_q, hold_v_d;
  logic              hold_rd_q, hold_rd_d;
  logic [ADDR_W-1:0] hold_addr_q, hold_addr_d;
  logic [DATA_W-1:0] hold_wdata_q, hold_wdata_d;
  logic              live_any;
  logic              capture;
  logic              drain;
  logic              load_en;

  assign live_any = live_wr | live_rd;

  always_comb begin
    if (hold_v_q) begin
      sel_wr    = ~hold_rd_q;
      sel_rd    = hold_rd_q;
      sel_addr  = hold_addr_q;
      sel_wdata = hold_wdata_q;
    end else begin
      sel_wr    = live_wr;
      sel_rd    = live_rd;
      sel_addr  = live_addr;
      sel_wdata = live_wdata;
    end
    req = hold_v_q | live_any;
  end

  always_comb begin
    capture      = live_any & (~take | hold_v_q);
    drain        = take & hold_v_q;
    load_en      = capture;
    hold_v_d     = hold_v_q;
    hold_rd_d    = hold_rd_q;
    hold_addr_d  = hold_addr_q;
    hold_wdata_d = hold_wdata_q;
    if (drain) hold_v_d = 1'b0;
    if (load_en) begin
      hold_v_d     = 1'b1;
      hold_rd_d    = live_rd;
      hold_addr_d  = live_addr;
      hold_wdata_d = live_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q     <= 1'b0;
      hold_rd_q    <= 1'b0;
      hold_addr_q  <= '0;
      hold_wdata_q <= '0;
    end else begin
      hold_v_q <= hold_v_d;
      if (load_en) begin
        hold_rd_q    <= hold_rd_d;
        hold_addr_q  <= hold_addr_d;
        hold_wdata_q <= hold_wdata_d;
      end
    end
  end

  // A strobe must not arrive while this port's slot is full and not draining (R6)
  assert_hold_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_any && hold_v_q) |-> take);

  // A requester never asks for a read and a write at once (R8)
  assert_live_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(live_wr && live_rd));
endmodule

// File: rtl/msa_pick.sv
module msa_pick (
  input  logic       busy,
  input  logic [1:0] req,
  output logic [1:0] take
);
  always_comb begin
    take = 2'b00;
    if (!busy) begin
      if (req[msa_pkg::PORT_A])      take[msa_pkg::PORT_A] = 1'b1;
      else if (req[msa_pkg::PORT_B]) take[msa_pkg::PORT_B] = 1'b1;
    end
  end
endmodule

// File: rtl/msa_ret_pipe.sv
module msa_ret_pipe #(
  parameter int LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_rd,
  input  msa_pkg::ret_tag_e issue_tag,
  output logic              busy,
  output logic              ret_v,
  output msa_pkg::ret_tag_e ret_tag
);
  logic [LAT-1:0] v_q, v_d;
  logic [LAT-1:0] t_q, t_d;

  always_comb begin
    v_d[0] = issue_rd;
    t_d[0] = issue_tag;
    for (int i = 1; i < LAT; i++) begin
      v_d[i] = v_q[i-1];
      t_d[i] = t_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      t_q <= '0;
    end else begin
      v_q <= v_d;
      t_q <= t_d;
    end
  end

  assign busy    = |v_q;
  assign ret_v   = v_q[LAT-1];
  assign ret_tag = msa_pkg::ret_tag_e'(t_q[LAT-1]);

  // At most one read is ever in flight (R6)
  assert_one_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(v_q));
endmodule

// File: rtl/mem_share_arb.sv
module mem_share_arb #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic              a_wr_i,
  input  logic              a_rd_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_rvalid_o,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  input  logic              b_wr_i,
  input  logic              b_rd_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_wr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  import msa_pkg::*;

  localparam int NP = NUM_PORTS;

  logic [NP-1:0]     live_wr, live_rd, req, take, sel_wr, sel_rd;
  logic [ADDR_W-1:0] live_addr [NP];
  logic [DATA_W-1:0] live_wdata [NP];
  logic [ADDR_W-1:0] sel_addr [NP];
  logic [DATA_W-1:0] sel_wdata [NP];
  logic              busy, ret_v, issue_rd;
  ret_tag_e          ret_tag, issue_tag;

  assign live_wr    = {b_wr_i, a_wr_i};
  assign live_rd    = {b_rd_i, a_rd_i};
  assign live_addr[PORT_A]  = a_addr_i;
  assign live_addr[PORT_B]  = b_addr_i;
  assign live_wdata[PORT_A] = a_wdata_i;
  assign live_wdata[PORT_B] = b_wdata_i;

  for (genvar p = 0; p < NP; p++) begin : g_slot
    msa_hold_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .live_wr    (live_wr[p]),
      .live_rd    (live_rd[p]),
      .live_addr  (live_addr[p]),
      .live_wdata (live_wdata[p]),
      .take       (take[p]),
      .req        (req[p]),
      .sel_wr     (sel_wr[p]),
      .sel_rd     (sel_rd[p]),
      .sel_addr   (sel_addr[p]),
      .sel_wdata  (sel_wdata[p])
    );
  end

  msa_pick u_pick (
    .busy (busy),
    .req  (req),
    .take (take)
  );

  always_comb begin
    if (take[PORT_B]) begin
      mem_addr_o  = sel_addr[PORT_B];
      mem_wdata_o = sel_wdata[PORT_B];
      mem_wr_o    = sel_wr[PORT_B];
      mem_rd_o    = sel_rd[PORT_B];
    end else begin
      mem_addr_o  = sel_addr[PORT_A];
      mem_wdata_o = sel_wdata[PORT_A];
      mem_wr_o    = take[PORT_A] & sel_wr[PORT_A];
      mem_rd_o    = take[PORT_A] & sel_rd[PORT_A];
    end
    issue_rd  = mem_rd_o;
    issue_tag = take[PORT_B] ? TAG_B : TAG_A;
  end

  msa_ret_pipe #(.LAT(RD_LAT)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_rd  (issue_rd),
    .issue_tag (issue_tag),
    .busy      (busy),
    .ret_v     (ret_v),
    .ret_tag   (ret_tag)
  );

  assign a_rdata_o  = mem_rdata_i;
  assign b_rdata_o  = mem_rdata_i;
  assign a_rvalid_o = ret_v & (ret_tag == TAG_A);
  assign b_rvalid_o = ret_v & (ret_tag == TAG_B);

  assert_one_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_o && mem_rd_o));

  assert_single_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_rvalid_o, b_rvalid_o}));

  assert_quiet_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !(mem_rd_o || mem_wr_o));

  assert_write_no_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> ##1 !(a_rvalid_o || b_rvalid_o));
endmodule

// File: tb/mem_share_arb_tb.sv
`timescale 1ns/1ps
module mem_share_arb_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] a_addr, b_addr, m_addr;
  logic [7:0]  a_wdata, b_wdata, a_rdata, b_rdata, m_wdata, m_rdata;
  logic a_wr, a_rd, b_wr, b_rd, a_rvalid, b_rvalid, m_wr, m_rd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_rd = -100;
  int due_q[$];
  int port_q[$];
  logic [19:0] adr_q[$];
  bit pv[2];
  bit prd[2];
  logic [19:0] padr[2];
  logic [7:0]  pdat[2];
  logic [19:0] h1 = '0, h2 = '0;

  always #2 clk = ~clk;

  mem_share_arb u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_addr_i(a_addr), .a_wdata_i(a_wdata), .a_wr_i(a_wr), .a_rd_i(a_rd),
    .a_rdata_o(a_rdata), .a_rvalid_o(a_rvalid),
    .b_addr_i(b_addr), .b_wdata_i(b_wdata), .b_wr_i(b_wr), .b_rd_i(b_rd),
    .b_rdata_o(b_rdata), .b_rvalid_o(b_rvalid),
    .mem_addr_o(m_addr), .mem_wdata_o(m_wdata), .mem_wr_o(m_wr), .mem_rd_o(m_rd),
    .mem_rdata_i(m_rdata)
  );

  function automatic logic [7:0] hashf(logic [19:0] ad);
    return ad[7:0] ^ ad[15:8] ^ {4'h5, ad[19:16]};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic model_clear();
    pv[0] = 0; pv[1] = 0;
    due_q.delete(); port_q.delete(); adr_q.delete();
    last_rd = -100;
    h1 = '0; h2 = '0;
  endtask

  task automatic step(bit aw, bit ar, logic [19:0] aa, logic [7:0] ad,
                      bit bw, bit br, logic [19:0] ba, logic [7:0] bd);
    bit lwr[2], lrd[2], cwr[2], crd[2], have[2], ev[2], busy, from_hold;
    logic [19:0] ladr[2], cadr[2];
    logic [7:0] ldat[2], cdat[2], ed;
    logic [19:0] eaddr;
    logic [7:0] edat;
    bit ewr, erd;
    int g, src;
    string lbl;
    @(negedge clk);
    a_wr = aw; a_rd = ar; a_addr = aa; a_wdata = ad;
    b_wr = bw; b_rd = br; b_addr = ba; b_wdata = bd;
    m_rdata = hashf(h2);
    #1;
    lwr[0] = aw; lrd[0] = ar; ladr[0] = aa; ldat[0] = ad;
    lwr[1] = bw; lrd[1] = br; ladr[1] = ba; ldat[1] = bd;
    busy = (cyc - last_rd >= 1) && (cyc - last_rd <= 2);
    for (int p = 0; p < 2; p++) begin
      have[p] = pv[p] | lwr[p] | lrd[p];
      if (pv[p]) begin cwr[p] = !prd[p]; crd[p] = prd[p]; cadr[p] = padr[p]; cdat[p] = pdat[p]; end
      else begin cwr[p] = lwr[p]; crd[p] = lrd[p]; cadr[p] = ladr[p]; cdat[p] = ldat[p]; end
    end
    g = -1;
    if (!busy) begin
      if (have[0]) g = 0;
      else if (have[1]) g = 1;
    end
    src = (g == 1) ? 1 : 0;
    eaddr = cadr[src]; edat = cdat[src];
    ewr = (g >= 0) ? cwr[src] : 1'b0;
    erd = (g >= 0) ? crd[src] : 1'b0;
    from_hold = (g >= 0) && pv[src];
    if (g < 0) lbl = "R1";
    else if (g == 0 && pv[0] && pv[1]) lbl = "R10";
    else if (g == 0) lbl = from_hold ? "R6" : "R2";
    else lbl = from_hold ? "R4" : "R3";
    check(m_wr === ewr && m_rd === erd, lbl, "strobes{wr,rd}", {m_wr, m_rd}, {ewr, erd});
    check(m_addr === eaddr && m_wdata === edat, lbl, "addr/wdata", {m_addr, m_wdata}, {eaddr, edat});
    check(!(m_wr && m_rd), "R8", "wr&rd", {m_wr, m_rd}, 0);
    ev[0] = 0; ev[1] = 0; ed = '0;
    foreach (due_q[i]) if (due_q[i] == cyc) begin ev[port_q[i]] = 1; ed = hashf(adr_q[i]); end
    check(a_rvalid === ev[0], ev[0] ? "R5" : "R7", "a_rvalid", a_rvalid, ev[0]);
    check(b_rvalid === ev[1], ev[1] ? "R5" : "R7", "b_rvalid", b_rvalid, ev[1]);
    if (ev[0]) check(a_rdata === ed, "R5", "a_rdata", a_rdata, ed);
    if (ev[1]) check(b_rdata === ed, "R5", "b_rdata", b_rdata, ed);
    if (g >= 0 && crd[src]) begin
      due_q.push_back(cyc + 2); port_q.push_back(src); adr_q.push_back(cadr[src]);
      last_rd = cyc;
    end
    for (int p = 0; p < 2; p++) begin
      bit was_held = pv[p];
      if (g == p && was_held) pv[p] = 0;
      if ((lwr[p] || lrd[p]) && !(g == p && !was_held)) begin
        pv[p] = 1; prd[p] = lrd[p]; padr[p] = ladr[p]; pdat[p] = ldat[p];
      end
    end
    h2 = h1;
    h1 = m_rd ? m_addr : '0;
    for (int i = due_q.size() - 1; i >= 0; i--)
      if (due_q[i] <= cyc) begin due_q.delete(i); port_q.delete(i); adr_q.delete(i); end
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 20'h0, 8'h0, 0, 0, 20'h0, 8'h0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check(a_rvalid === 1'b0 && b_rvalid === 1'b0, "R9", "rvalid in reset", {a_rvalid, b_rvalid}, 0);
      check(m_wr === 1'b0 && m_rd === 1'b0, "R9", "strobes in reset", {m_wr, m_rd}, 0);
    end
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
    a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0; m_rdata = '0;
    model_clear();
    apply_reset();
    // R1: idle, memory side follows port A's live inputs
    step(0, 0, 20'h12345, 8'hA5, 0, 0, 20'h0BEEF, 8'h11);
    // R2: lone A write then lone A read, R5 return
    step(1, 0, 20'h00010, 8'h3C, 0, 0, 20'h0, 8'h0);
    step(0, 1, 20'h00020, 8'h00, 0, 0, 20'h0, 8'h0);
    idle(3);
    // R3: lone B read and write; R7 write does not block
    step(0, 0, 20'h0, 8'h0, 0, 1, 20'hABCDE, 8'h00);
    idle(3);
    step(0, 0, 20'h0, 8'h0, 1, 0, 20'h55555, 8'h77);
    step(1, 0, 20'h00777, 8'h01, 0, 0, 20'h0, 8'h0);
    // R4: simultaneous writes, then simultaneous reads
    step(1, 0, 20'h00100, 8'h10, 1, 0, 20'h00200, 8'h20);
    idle(1);
    step(0, 1, 20'h00300, 8'h00, 0, 1, 20'h00400, 8'h00);
    idle(6);
    // R6, R10: strobes during read blackout on both ports
    step(0, 1, 20'h01000, 8'h00, 0, 0, 20'h0, 8'h0);
    step(0, 0, 20'h0, 8'h0, 1, 0, 20'h02000, 8'h42);
    step(1, 0, 20'h03000, 8'h43, 0, 0, 20'h0, 8'h0);
    idle(4);
    // held request draining while a fresh strobe arrives on the same port
    step(0, 1, 20'h04000, 8'h00, 0, 0, 20'h0, 8'h0);
    step(0, 1, 20'h05000, 8'h00, 0, 0, 20'h0, 8'h0);
    idle(1);
    step(0, 1, 20'h06000, 8'h00, 0, 0, 20'h0, 8'h0);
    idle(8);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int ra, rb;
      bit aw, ar, bw, br;
      ra = $urandom % 5; rb = $urandom % 5;
      aw = !pv[0] && ra == 0; ar = !pv[0] && ra == 1;
      bw = !pv[1] && rb == 0; br = !pv[1] && rb == 1;
      step(aw, ar, 20'($urandom), 8'($urandom), bw, br, 20'($urandom), 8'($urandom));
    end
    idle(6);
    // R9: reset while a read is in flight and a request is held
    step(0, 1, 20'h0AAAA, 8'h00, 0, 0, 20'h0, 8'h0);
    step(0, 0, 20'h0, 8'h0, 0, 1, 20'h0BBBB, 8'h00);
    apply_reset();
    idle(6);
    step(0, 1, 20'h0CCCC, 8'h00, 0, 0, 20'h0, 8'h0);
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule